// File: doc/BRIEF.md
# Accelerometer Control Link over I2C (Target Side)

This block is the serial target port of a two-axis acceleration sensor. It oversamples the I2C clock and data lines with the system clock, finds START and STOP conditions, and answers one 7-bit address. The upper four address bits are fixed and the lower three come from strap pins. The SDA pin is open-drain: the block only ever pulls the line low, signalled by `sda_oe_o`.

A write sets a single 4-bit control register: power-down, self-test, bandgap test and temperature select. A read streams a five-byte frame made of the control register, the X-or-temperature word and the Y word. The sample words are 12-bit parallel inputs from a separate refresh block. The frame is frozen when the read address is acknowledged, so a burst never mixes two samples.

Top module: `accel_i2c_target`

## Requirements
- R1: A START (SDA falling while SCL is high) begins a new address phase from any state, including in the middle of a transfer. A STOP (SDA rising while SCL is high) returns the port to idle.
- R2: The address byte is sent MSB first as `{4'b0010, strap_i, dir}`, where dir 1 means read and 0 means write. On a match the target pulls SDA low for the ninth clock. On a mismatch it does not acknowledge, and it ignores everything up to the next START or STOP.
- R3: In a write, the first data byte is the register address. The value 0x00 is acknowledged. Any other value is not acknowledged, and the bytes that follow are ignored.
- R4: The byte after the register address is acknowledged, and its bits [3:0] are stored in the control register on `ctrl_o`: bit 0 power-down, bit 1 self-test, bit 2 bandgap test, bit 3 temperature select. Bits [7:4] are dropped and read back as zero. Any further byte in the same write is not acknowledged and changes nothing.
- R5: A read returns five bytes in this order: the control register, X/T high, X/T low, Y high, Y low.
- R6: Each axis word is 16 bits wide. The high byte is `{4'b0000, sample[11:8]}` and the low byte is `sample[7:0]`.
- R7: When control bit 3 is 1, the X/T slot carries `temp_i`. When it is 0, the slot carries `x_i`.
- R8: The target sends the next byte only after the controller acknowledges. After a controller NACK, or after the fifth byte, the target releases SDA until the next START.
- R9: The whole frame is captured when the read address is acknowledged. Changes on the sample inputs during a burst do not appear in that burst.
- R10: `sda_oe_o` set to 1 means the line is pulled low. It changes only while SCL is low.
- R11: After reset, `sda_oe_o` is 0 and the control register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line, asynchronous |
| sda_i | input | 1 | I2C data line as seen on the pad, asynchronous |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| strap_i | input | 3 | Lower three address bits |
| x_i | input | 12 | X acceleration sample |
| temp_i | input | 12 | Temperature sample |
| y_i | input | 12 | Y acceleration sample |
| ctrl_o | output | 4 | Control register: {temp_sel, bg_test, self_test, power_down} |

## Verification
Two full bursts are read, with temperature select set and then cleared. Since the X, temperature and Y inputs hold distinct values, these bursts separate the slot order, the zero fill and the slot source. The write path is tried with a foreign address, a nonzero register address, a control byte with its upper bits set and a trailing extra byte. Each of these shows whether a mismatch is refused without side effects. Reads that end early, that run past five bytes, that are broken by a repeated START, or whose inputs change in the middle of the burst separate the controller-acknowledge rule, the end of the burst, the restart behaviour and the frame capture.

// File: rtl/accel_i2c_pkg.sv
package accel_i2c_pkg;
  localparam int CTRL_W      = 4;
  localparam int FRAME_BYTES = 5;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_REG,
    S_CTRL,
    S_READ,
    S_SKIP
  } link_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // SDA edge while SCL stays high
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/accel_frame_shadow.sv
module accel_frame_shadow
  import accel_i2c_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                capture_i,
  input  logic [CTRL_W-1:0]   ctrl_i,
  input  logic [SAMPLE_W-1:0] x_i,
  input  logic [SAMPLE_W-1:0] temp_i,
  input  logic [SAMPLE_W-1:0] y_i,
  input  logic [2:0]          sel_i,
  output logic [7:0]          byte_o
);
  localparam int WORD_W = 16;
  localparam int PAD_W  = WORD_W - SAMPLE_W;

  logic [7:0] shadow_q [FRAME_BYTES];
  logic [7:0] fresh    [FRAME_BYTES];
  logic [SAMPLE_W-1:0] xt_sel;
  logic [WORD_W-1:0]   xt_word, y_word;

  assign xt_sel  = ctrl_i[3] ? temp_i : x_i;
  assign xt_word = {{PAD_W{1'b0}}, xt_sel};
  assign y_word  = {{PAD_W{1'b0}}, y_i};

  always_comb begin
    fresh[0] = {{(8-CTRL_W){1'b0}}, ctrl_i};
    fresh[1] = xt_word[15:8];
    fresh[2] = xt_word[7:0];
    fresh[3] = y_word[15:8];
    fresh[4] = y_word[7:0];
  end

  for (genvar g = 0; g < FRAME_BYTES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        shadow_q[g] <= '0;
      else if (capture_i) shadow_q[g] <= fresh[g];
    end
  end

  assign byte_o = (int'(sel_i) < FRAME_BYTES) ? shadow_q[sel_i] : 8'h00;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import accel_i2c_pkg::*;
#(
  parameter logic [3:0] ADDR_PREFIX = 4'b0010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [2:0]        strap_i,
  input  logic [7:0]        frame_i,
  output logic [2:0]        sel_o,
  output logic              capture_o,
  output logic              sda_oe_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  localparam logic [2:0] LAST_IDX = 3'(FRAME_BYTES - 1);

  link_state_e        st_q;
  logic [3:0]         bit_cnt_q;
  logic [7:0]         sh_q;
  logic [2:0]         idx_q;
  logic               rnw_q, mst_ack_q, oe_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic               active, addr_hit;

  assign active    = (st_q != S_IDLE) && (st_q != S_SKIP);
  assign addr_hit  = (sh_q[7:1] == {ADDR_PREFIX, strap_i});
  assign capture_o = scl_fall_i && !start_i && !stop_i && st_q == S_ADDR &&
                     bit_cnt_q == 4'd8 && addr_hit && sh_q[0];
  assign sel_o     = (st_q == S_READ) ? 3'(idx_q + 3'd1) : 3'd0;
  assign sda_oe_o  = oe_q;
  assign ctrl_o    = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= S_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      idx_q     <= '0;
      rnw_q     <= 1'b0;
      mst_ack_q <= 1'b0;
      oe_q      <= 1'b0;
      ctrl_q    <= '0;
    end else if (start_i) begin
      st_q      <= S_ADDR;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (stop_i) begin
      st_q      <= S_IDLE;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (scl_rise_i && active) begin
      if (bit_cnt_q < 4'd8 && st_q != S_READ) sh_q <= {sh_q[6:0], sda_i};
      if (bit_cnt_q == 4'd8) mst_ack_q <= ~sda_i;
      bit_cnt_q <= bit_cnt_q + 4'd1;
    end else if (scl_fall_i && active) begin
      if (bit_cnt_q == 4'd8) begin
        // eighth bit done: open the acknowledge slot
        unique case (st_q)
          S_ADDR: if (addr_hit) begin
                    oe_q  <= 1'b1;
                    rnw_q <= sh_q[0];
                  end else st_q <= S_SKIP;
          S_REG:  if (sh_q == 8'h00) oe_q <= 1'b1;
                  else st_q <= S_SKIP;
          S_CTRL: begin
                    ctrl_q <= sh_q[CTRL_W-1:0];
                    oe_q   <= 1'b1;
                  end
          default: oe_q <= 1'b0;
        endcase
      end else if (bit_cnt_q == 4'd9) begin
        bit_cnt_q <= '0;
        oe_q      <= 1'b0;
        unique case (st_q)
          S_ADDR: if (rnw_q) begin
                    st_q  <= S_READ;
                    idx_q <= '0;
                    sh_q  <= frame_i;
                    oe_q  <= ~frame_i[7];
                  end else st_q <= S_REG;
          S_REG:  st_q <= S_CTRL;
          S_CTRL: st_q <= S_SKIP;
          default: if (mst_ack_q && idx_q < LAST_IDX) begin
                    idx_q <= idx_q + 3'd1;
                    sh_q  <= frame_i;
                    oe_q  <= ~frame_i[7];
                  end else st_q <= S_SKIP;
        endcase
      end else if (st_q == S_READ) begin
        sh_q <= {sh_q[6:0], 1'b0};
        oe_q <= ~sh_q[6];
      end
    end
  end

  p_oe_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> $past(!scl_i));
  p_ctrl_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_q) |-> $past(st_q == S_CTRL));
  p_quiet_when_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IDLE || st_q == S_SKIP) |-> !oe_q);
  p_bit_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_q <= 4'd9);
  p_burst_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST_IDX);
  p_start_rearms_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (st_q == S_ADDR && bit_cnt_q == 4'd0));
endmodule

// File: rtl/accel_i2c_target.sv
module accel_i2c_target
  import accel_i2c_pkg::*;
#(
  parameter logic [3:0] ADDR_PREFIX = 4'b0010,
  parameter int         SAMPLE_W    = 12,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  input  logic [2:0]          strap_i,
  input  logic [SAMPLE_W-1:0] x_i,
  input  logic [SAMPLE_W-1:0] temp_i,
  input  logic [SAMPLE_W-1:0] y_i,
  output logic [CTRL_W-1:0]   ctrl_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev, capture;
  logic [2:0] sel;
  logic [7:0] frame_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  accel_frame_shadow #(.SAMPLE_W(SAMPLE_W)) u_frame (
    .clk_i, .rst_ni,
    .capture_i(capture), .ctrl_i(ctrl_o),
    .x_i, .temp_i, .y_i,
    .sel_i(sel), .byte_o(frame_byte)
  );

  i2c_byte_engine #(.ADDR_PREFIX(ADDR_PREFIX)) u_engine (
    .clk_i, .rst_ni,
    .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_ev), .stop_i(stop_ev),
    .strap_i, .frame_i(frame_byte),
    .sel_o(sel), .capture_o(capture),
    .sda_oe_o, .ctrl_o
  );
endmodule

// File: tb/sim_accel_i2c_target.sv
module sim_accel_i2c_target;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [2:0]  strap = 3'b101;
  logic [11:0] x_in = 12'hABC, t_in = 12'h123, y_in = 12'h7E5;
  logic [3:0]  ctrl;
  logic sda_bus;
  int checks = 0, fails = 0, r10_viol = 0;
  logic oe_prev = 1'b0;

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  accel_i2c_target u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .strap_i(strap), .x_i(x_in), .temp_i(t_in),
    .y_i(y_in), .ctrl_o(ctrl)
  );

  // R10 monitor: drive may only change while SCL is low
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m) r10_viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_bus; wq(); scl_m = 1'b0; wq();
    end
    sda_m = ~give_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] cval, input string tag);
    logic a;
    bus_start();
    send_byte(8'h2A, a); chk({7'd0, a}, 8'd1, {tag, " R2 addr ack"});
    send_byte(8'h00, a); chk({7'd0, a}, 8'd1, {tag, " R3 reg ack"});
    send_byte(cval, a);  chk({7'd0, a}, 8'd1, {tag, " R4 ctrl ack"});
    bus_stop();
  endtask

  task automatic do_read5(input logic [7:0] e0, e1, e2, e3, e4, input string tag);
    logic a;
    logic [7:0] b;
    logic [7:0] exp [5];
    exp = '{e0, e1, e2, e3, e4};
    bus_start();
    send_byte(8'h2B, a); chk({7'd0, a}, 8'd1, {tag, " R2 read addr ack"});
    for (int k = 0; k < 5; k++) begin
      recv_byte(k < 4, b);
      chk(b, exp[k], $sformatf("%s R5 byte %0d", tag, k));
    end
    bus_stop();
  endtask

  task automatic t_reset();
    chk({7'd0, sda_oe}, 8'd0, "R11 sda_oe after reset");
    chk({4'd0, ctrl}, 8'd0, "R11 ctrl after reset");
  endtask

  task automatic t_temp_slot();
    do_write(8'h0B, "temp");
    chk({4'd0, ctrl}, 8'h0B, "R4 ctrl stored");
    do_read5(8'h0B, 8'h01, 8'h23, 8'h07, 8'hE5, "R7 temp slot");
  endtask

  task automatic t_x_slot();
    do_write(8'h00, "x");
    do_read5(8'h00, 8'h0A, 8'hBC, 8'h07, 8'hE5, "R6 x slot");
  endtask

  task automatic t_wrong_addr();
    logic a;
    bus_start();
    send_byte(8'h28, a); chk({7'd0, a}, 8'd0, "R2 foreign addr nack");
    send_byte(8'h00, a); chk({7'd0, a}, 8'd0, "R2 ignored reg byte");
    send_byte(8'h0F, a); chk({7'd0, a}, 8'd0, "R2 ignored ctrl byte");
    bus_stop();
    chk({4'd0, ctrl}, 8'h00, "R2 ctrl untouched");
  endtask

  task automatic t_bad_reg();
    logic a;
    bus_start();
    send_byte(8'h2A, a); chk({7'd0, a}, 8'd1, "R3 addr ack");
    send_byte(8'h01, a); chk({7'd0, a}, 8'd0, "R3 nonzero reg nack");
    send_byte(8'h0F, a); chk({7'd0, a}, 8'd0, "R3 follow byte ignored");
    bus_stop();
    chk({4'd0, ctrl}, 8'h00, "R3 ctrl untouched");
  endtask

  task automatic t_upper_bits();
    logic a;
    bus_start();
    send_byte(8'h2A, a);
    send_byte(8'h00, a);
    send_byte(8'hF5, a); chk({7'd0, a}, 8'd1, "R4 ctrl ack");
    send_byte(8'h33, a); chk({7'd0, a}, 8'd0, "R4 extra byte nack");
    bus_stop();
    chk({4'd0, ctrl}, 8'h05, "R4 upper bits dropped");
  endtask

  task automatic t_early_nack();
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'h2B, a);
    recv_byte(1'b0, b); chk(b, 8'h05, "R5 ctrl readback");
    recv_byte(1'b0, b); chk(b, 8'hFF, "R8 released after nack");
    bus_stop();
  endtask

  task automatic t_shadow();
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'h2B, a);
    recv_byte(1'b1, b); chk(b, 8'h05, "R9 byte 0");
    x_in = 12'h456; y_in = 12'h321;
    recv_byte(1'b1, b); chk(b, 8'h0A, "R9 x high frozen");
    recv_byte(1'b1, b); chk(b, 8'hBC, "R9 x low frozen");
    recv_byte(1'b1, b); chk(b, 8'h07, "R9 y high frozen");
    recv_byte(1'b1, b); chk(b, 8'hE5, "R9 y low frozen");
    recv_byte(1'b0, b); chk(b, 8'hFF, "R8 released after fifth");
    bus_stop();
    do_read5(8'h05, 8'h04, 8'h56, 8'h03, 8'h21, "R9 next burst fresh");
  endtask

  task automatic t_restart();
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'h2A, a);
    send_byte(8'h00, a);
    bus_start();
    send_byte(8'h2B, a); chk({7'd0, a}, 8'd1, "R1 repeated start addr ack");
    recv_byte(1'b0, b); chk(b, 8'h05, "R1 ctrl kept across restart");
    bus_stop();
    chk({4'd0, ctrl}, 8'h05, "R1 ctrl unchanged");
  endtask

  task automatic summary();
    checks++;
    if (r10_viol != 0) begin
      fails++;
      $display("FAIL R10: actual %0d drive changes with SCL high, expected 0", r10_viol);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_temp_slot();
    t_x_slot();
    t_wrong_addr();
    t_bad_reg();
    t_upper_bits();
    t_early_nack();
    t_shadow();
    t_restart();
    summary();
  end
endmodule